// File: doc/BRIEF.md
# Prescaled Halt Timer

This block is a one-shot interval timer for a small embedded controller. Software programs a prescale code and a 12-bit timeout through a two-register write/read port, then sets an enable bit. A fixed three-cycle start-up phase runs first. After it, a prescaler divides the master clock by twice the selected divisor, and each divided tick advances a 12-bit up-counter. When the counter reaches the timeout, a sticky done flag sets and the counter stops.

If software also sets a halt-enable bit, the block raises a halt request to the processor. It can set that bit together with the enable bit or later, while the timer is already counting. The request falls in the same cycle that the done flag rises, so the processor can sleep for exactly the programmed interval and then resume. Clearing the enable bit abandons a run and zeroes the count. The done flag is cleared either by a write-one-to-clear or by a fresh enable.

Top module: `prescaled_halt_timer`

## Requirements
- R1: After reset both registers read zero, `done` is 0 and `halt_req` is 0.
- R2: The control register sits at address 20h with bit 0 = enable, bit 1 = halt enable and bit 2 = done (reads the flag). The configuration register sits at address 21h with bits [11:0] = timeout and bits [15:12] = prescale code. `rd_data` shows the addressed register combinationally.
- R3: Prescale code c selects divisor N = c+1 for c below 8, and N = 2^(c-4) for c from 8 to 15.
- R4: Suppose a control write turns the enable bit from 0 to 1 at clock edge E. Then `done` reads 1 exactly after edge E + 2·N·T + 3, where T is the timeout, and not earlier.
- R5: With a timeout of zero, `done` sets after edge E + 3, so the timer never waits for a counter wrap.
- R6: `done` stays 1 until one of two things happens: a control write with bit 2 = 1, or a 0-to-1 enable write. Once `done` is set, the timer does not count again while the enable bit stays 1.
- R7: While a run is in progress and halt enable is 1, `halt_req` is 1. This holds whether halt enable was written together with the enable bit or later, during counting. `halt_req` drops in the cycle `done` sets.
- R8: Writing the enable bit to 0 stops a run, zeroes the counter and drops `halt_req`, and leaves `done` unchanged. A later enable runs the full interval again.
- R9: Writes to any address other than 20h and 21h change nothing, and such addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Contents of the addressed register |
| done | output | 1 | Sticky interval-complete flag |
| halt_req | output | 1 | Stall request to the processor |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the configuration register is not rewritten while a run is in progress, because the counter compares against the live timeout. The stimulus writes the configuration only while the enable bit is 0 or after `done` has set. It issues one write per transaction, with idle cycles between writes. Turning halt enable on in the middle of a run uses a control write that keeps the enable bit at 1, so that write starts nothing new.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PS_W     = 4;
    localparam int CNT_W    = 12;
    localparam int DATA_W   = PS_W + CNT_W;
    localparam int ADDR_W   = 8;
    localparam int EN_BIT   = 0;
    localparam int HEN_BIT  = 1;
    localparam int DONE_BIT = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WARM,
        PH_COUNT,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        logic [PS_W-1:0]  code;
        logic [CNT_W-1:0] limit;
    } cfg_t;

    typedef struct packed {
        logic done;
        logic hen;
        logic en;
    } ctrl_t;

    // Divisor N for a prescale code: linear for low codes, powers of two above.
    function automatic logic [CNT_W-1:0] div_of(input logic [PS_W-1:0] code);
        int n;
        if (code < 4'd8) n = int'(code) + 1;
        else             n = 1 << (int'(code) - 4);
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);

    logic [W-1:0] pc;
    logic [W:0]   lim;

    // One tick every 2*div input cycles.
    always_comb begin
        lim  = {div, 1'b0} - 1'b1;
        tick = run && ({1'b0, pc} >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pc <= '0;
        end else if (run) begin
            pc <= tick ? '0 : pc + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int WARM_CYC = 3,
    parameter int W        = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         stop,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output phase_e       phase,
    output logic [W-1:0] count,
    output logic         done_set
);

    localparam int SW = $clog2(WARM_CYC + 1);

    logic [SW-1:0] st;
    logic [W-1:0]  nxt;
    logic          warm_last;

    always_comb begin
        nxt       = count + 1'b1;
        warm_last = (phase == PH_WARM) && (st == SW'(WARM_CYC - 1));
        done_set  = (warm_last && (limit == '0)) ||
                    ((phase == PH_COUNT) && tick && (nxt == limit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            st    <= '0;
            count <= '0;
        end else if (stop) begin
            phase <= PH_IDLE;
            st    <= '0;
            count <= '0;
        end else if (start) begin
            phase <= PH_WARM;
            st    <= '0;
            count <= '0;
        end else begin
            unique case (phase)
                PH_WARM: begin
                    st <= st + 1'b1;
                    if (warm_last) phase <= (limit == '0) ? PH_FINISH : PH_COUNT;
                end
                PH_COUNT: begin
                    if (tick) begin
                        count <= nxt;
                        if (nxt == limit) phase <= PH_FINISH;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0)); // R4

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_set,
    output cfg_t              cfg,
    output ctrl_t             ctrl,
    output logic              start,
    output logic              stop,
    output logic [DATA_W-1:0] rd_data
);

    logic wr_ctrl, wr_cfg, clr;

    always_comb begin
        wr_ctrl = wr_en && (addr == CTRL_OFS);
        wr_cfg  = wr_en && (addr == CFG_OFS);
        start   = wr_ctrl && !ctrl.en &&  wdata[EN_BIT];
        stop    = wr_ctrl &&  ctrl.en && !wdata[EN_BIT];
        clr     = start || (wr_ctrl && wdata[DONE_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en  <= wdata[EN_BIT];
                ctrl.hen <= wdata[HEN_BIT];
            end
            if (wr_cfg) cfg <= cfg_t'(wdata);
            ctrl.done <= (ctrl.done && !clr) || done_set;
        end
    end

    always_comb begin
        if (addr == CTRL_OFS)     rd_data = DATA_W'(ctrl);
        else if (addr == CFG_OFS) rd_data = DATA_W'(cfg);
        else                      rd_data = '0;
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl.done && !wr_ctrl) |=> ctrl.done); // R6

endmodule

// File: rtl/prescaled_halt_timer.sv
module prescaled_halt_timer
    import tmr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h21,
    parameter int                WARM_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              halt_req
);

    cfg_t             cfg;
    ctrl_t            ctrl;
    phase_e           phase;
    logic [CNT_W-1:0] count;
    logic             start, stop, tick, done_set;

    tmr_regs #(
        .CTRL_OFS (CTRL_OFS),
        .CFG_OFS  (CFG_OFS)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wr_data),
        .done_set (done_set),
        .cfg      (cfg),
        .ctrl     (ctrl),
        .start    (start),
        .stop     (stop),
        .rd_data  (rd_data)
    );

    tmr_prescaler #(.W(CNT_W)) i_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (phase != PH_COUNT),
        .run   (phase == PH_COUNT),
        .div   (div_of(cfg.code)),
        .tick  (tick)
    );

    tmr_core #(.WARM_CYC(WARM_CYC), .W(CNT_W)) i_core (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .tick     (tick),
        .limit    (cfg.limit),
        .phase    (phase),
        .count    (count),
        .done_set (done_set)
    );

    always_comb begin
        done     = ctrl.done;
        halt_req = ctrl.hen && ((phase == PH_WARM) || (phase == PH_COUNT));
    end

    AST_HALT_DROPS: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !halt_req); // R7

    AST_HALT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> ctrl.en); // R7

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> (phase == PH_IDLE && count == '0)); // R8

endmodule

// File: tb/test_prescaled_halt_timer.sv
module test_prescaled_halt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h20;
    logic [15:0] wr_data = '0;
    wire  [15:0] rd_data;
    wire         done, halt_req;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit        m_en, m_hen, m_done, m_run, fire;
    int        m_rem;
    bit [3:0]  m_code;
    bit [11:0] m_to;

    always #2 clk = ~clk;

    prescaled_halt_timer i_prescaled_halt_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .halt_req(halt_req)
    );

    function automatic int div_n(int c);
        return (c < 8) ? c + 1 : (1 << (c - 4));
    endfunction

    function automatic logic [15:0] model_rd(logic [7:0] a);
        if (a == 8'h20) return {13'd0, m_done, m_hen, m_en};
        if (a == 8'h21) return {m_code, m_to};
        return 16'd0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model, compared one time unit after every edge
    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_hen = 0; m_done = 0; m_run = 0; m_rem = 0;
            m_code = 0; m_to = 0;
        end else begin
            fire = m_run && (m_rem == 1);
            if (m_run) m_rem--;
            if (fire) m_run = 0;
            if (wr_en && addr == 8'h20) begin
                if (!m_en && wr_data[0]) begin
                    m_run  = 1;
                    m_rem  = 2 * div_n(int'(m_code)) * int'(m_to) + 3;
                    m_done = 0;
                end else if (m_en && !wr_data[0]) begin
                    m_run = 0;
                end
                if (wr_data[2]) m_done = 0;
                m_en  = wr_data[0];
                m_hen = wr_data[1];
            end else if (wr_en && addr == 8'h21) begin
                {m_code, m_to} = wr_data;
            end
            if (fire) m_done = 1;
        end
        #1;
        if (!rst) begin
            chk("R4 done per-cycle", 32'(done), 32'(m_done));
            chk("R7 halt_req per-cycle", 32'(halt_req), 32'(m_hen && m_run));
            chk("R2 rd_data per-cycle", 32'(rd_data), 32'(model_rd(addr)));
        end
    end

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h20;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic measure(string req, int code, int to, bit hen);
        int n;
        wr(8'h21, {4'(code), 12'(to)});
        wr(8'h20, {14'd0, hen, 1'b1});
        wait_done(n);
        chk(req, 32'(n), 32'(2 * div_n(code) * to + 3));
        wr(8'h20, 16'h0004);
        wr(8'h20, 16'h0000);
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 done", 32'(done), 0);
        chk("R1 halt_req", 32'(halt_req), 0);
        chk("R1 ctrl", 32'(rd_data), 0);
        addr = 8'h21; #1;
        chk("R1 cfg", 32'(rd_data), 0);
        addr = 8'h20;

        // R2 map
        wr(8'h21, 16'h3ABC);
        addr = 8'h21; #1;
        chk("R2 cfg readback", 32'(rd_data), 32'h3ABC);
        addr = 8'h20;

        // R9 unmapped address
        wr(8'h22, 16'hFFFF);
        #1;
        chk("R9 ctrl untouched", 32'(rd_data), 0);
        chk("R9 done untouched", 32'(done), 0);
        addr = 8'h21; #1;
        chk("R9 cfg untouched", 32'(rd_data), 32'h3ABC);
        addr = 8'h22; #1;
        chk("R9 unmapped reads zero", 32'(rd_data), 0);
        addr = 8'h20;

        // R4 main interval and boundary
        measure("R4 interval code2 to5", 2, 5, 0);
        measure("R4 interval code7 to9", 7, 9, 0);
        measure("R4 interval max timeout", 0, 4095, 0);

        // R5 zero timeout
        measure("R5 zero timeout", 5, 0, 0);
        measure("R5 zero timeout code15", 15, 0, 1);

        // R3 every prescale code
        for (int c = 0; c < 16; c++) measure("R3 prescale code", c, 1, 0);

        // R7 halt enabled with enable
        wr(8'h21, {4'd1, 12'd4});
        wr(8'h20, 16'h0003);
        #1;
        chk("R7 halt with enable", 32'(halt_req), 1);
        wait_done(n);
        chk("R7 halt released at done", 32'(halt_req), 0);
        wr(8'h20, 16'h0004);
        wr(8'h20, 16'h0000);

        // R7 halt enabled during counting
        wr(8'h21, {4'd3, 12'd6});
        wr(8'h20, 16'h0001);
        idle(5);
        #1;
        chk("R7 no halt before set", 32'(halt_req), 0);
        wr(8'h20, 16'h0003);
        #1;
        chk("R7 halt set mid-run", 32'(halt_req), 1);
        wait_done(n);
        chk("R7 halt dropped", 32'(halt_req), 0);

        // R6 sticky done, one-shot
        idle(50);
        #1;
        chk("R6 done sticky", 32'(done), 1);
        wr(8'h20, 16'h0001);
        #1;
        chk("R6 plain write keeps done", 32'(done), 1);
        wr(8'h20, 16'h0005);
        #1;
        chk("R6 write-one clears done", 32'(done), 0);
        idle(120);
        #1;
        chk("R6 no re-run while enabled", 32'(done), 0);
        wr(8'h20, 16'h0000);

        // R8 stop mid-run, then full restart
        wr(8'h21, {4'd0, 12'd20});
        wr(8'h20, 16'h0003);
        idle(10);
        wr(8'h20, 16'h0000);
        #1;
        chk("R8 halt dropped on stop", 32'(halt_req), 0);
        idle(60);
        #1;
        chk("R8 stopped run never completes", 32'(done), 0);
        wr(8'h20, 16'h0001);
        wait_done(n);
        chk("R8 full interval after restart", 32'(n), 43);
        wr(8'h20, 16'h0000);
        #1;
        chk("R8 stop keeps done", 32'(done), 1);
        wr(8'h20, 16'h0001);
        #1;
        chk("R6 fresh enable clears done", 32'(done), 0);
        idle(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=expired expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule